// File: doc/BRIEF.md
# Multi-Context Interrupt Router

This block collects level interrupt lines from a parameterised set of sources and routes them to a small number of contexts. Each context is one interrupt-request output that a processor mode consumes. Software sees a word-addressed register space. It gives each source a priority and each context an enable mask, a threshold and a claim/complete port. Source 0 is reserved and never interrupts.

When a line rises, the source becomes pending in the lowest-numbered context that has it enabled, and the source's priority at that moment is latched for that context. A context requests an interrupt while one of its pending, unclaimed sources has a latched priority above the context threshold. Reading the claim port hands software the best such source and marks it claimed. Writing the source ID back releases the claim. Disabling a source, or dropping its line, withdraws it from the context.

The register bus is a valid/ready request with a registered response one cycle after acceptance. A double-word request becomes two word operations, at the address and at the address plus four, on consecutive cycles.

Top module: `irq_router`

## Requirements
- R1: Source N's priority is at byte 4*N. A write keeps only the low PRIO_W bits. Source 0 reads as zero, and writes to it are accepted without effect.
- R2: Context C's threshold is at byte 0x200000 + 0x1000*C and keeps only the low PRIO_W bits. Its claim/complete port is at that address plus 4.
- R3: A read at byte 0x1000 + 4*W returns bit b set when source 32*W+b is pending in any context.
- R4: Context C's enable word W is at byte 0x2000 + 0x80*C + 4*W and reads back as written, except that bit 0 of word 0 always reads zero.
- R5: An enable bit going 0 to 1 while the source line is high makes the source pending in that context and latches its current priority. An enable bit going 1 to 0 clears pending, claimed and the latched priority there.
- R6: A rising source line makes the source pending, with its priority latched, only in the lowest-index context enabling it. A falling line clears pending and claimed in that same context.
- R7: irq[C] is high exactly when a pending, unclaimed source in C has a latched priority strictly above C's threshold.
- R8: A claim read returns the eligible source with the highest latched priority, the lowest ID on a tie, or 0 if none exceeds the threshold. A nonzero result is marked claimed exactly once per accepted read.
- R9: A complete write of value V clears V's claimed bit only when V is below NSRC and enabled in that context. Any other value changes nothing.
- R10: Size code 3 runs word operations at A and A+4, responds once with the second word in bits 63:32, and skips the second half if the first write fails. Size codes 0 and 1, or any address with bits 1:0 nonzero, get an error response with zero data and have no effect.
- R11: Reads of unmapped or out-of-range offsets return zero without error. Writes to them, and to the pending words, are dropped and answered with an error.
- R12: A word request gets its response in the cycle after acceptance. A double-word request gets it two cycles after acceptance, and req_ready is low in between.
- R13: Within one cycle, the bus operation is applied first and source line changes second. A claim reads the state from before both, and a line change sees enables written in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NSRC | Source interrupt levels, bit 0 ignored |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double word |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 64 | Write data, low word first |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 64 | Read data |
| irq | output | NCTX | Interrupt request per context |

## Verification
Two things can land in the same cycle: a register operation and a source line change. Both can touch the same pending and claimed bits. The bench provokes this by driving the line change in the very cycle a request is accepted. It pairs a claim read with the claimed source's line falling, and an enable write with the enabled source's line rising. It also mixes both kinds of event at random. A behavioural model applies the bus operation first and the line change second. Every cycle, its responses and interrupt outputs are compared with the design's.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_irq,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [23:0]       req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic [NCTX-1:0]   irq
);
  localparam int IDW    = $clog2(NSRC);
  localparam int NWORDS = (NSRC + 31) / 32;

  typedef logic [NSRC-1:0] vec_t;
  typedef logic [NSRC-1:0][PRIO_W-1:0] pvec_t;

  vec_t en_q [NCTX], pend_q [NCTX], clm_q [NCTX];
  vec_t en_d [NCTX], pend_d [NCTX], clm_d [NCTX];
  pvec_t lp_q [NCTX], lp_d [NCTX];
  pvec_t prio_q, prio_d;
  logic [PRIO_W-1:0] thr_q [NCTX], thr_d [NCTX];
  vec_t lvl_q;

  logic        busy_q, hi_w_q;
  logic [21:0] hi_wa_q;
  logic [31:0] hi_d_q, lo_q;
  logic [IDW-1:0] best [NCTX];

  logic acc, bad_req, op_v, op_w;
  logic [21:0] op_a;
  logic [31:0] op_d;
  assign req_ready = ~busy_q;
  assign acc       = req_valid & req_ready;
  assign bad_req   = ~req_size[1] | (req_addr[1:0] != 2'b00);
  assign op_v      = busy_q | (acc & ~bad_req);
  assign op_w      = busy_q ? hi_w_q  : req_write;
  assign op_a      = busy_q ? hi_wa_q : req_addr[23:2];
  assign op_d      = busy_q ? hi_d_q  : req_wdata[31:0];

  logic r_prio, r_pend, r_en;
  logic [9:0]  lo_idx;
  logic [21:0] eo;
  logic [16:0] en_c;
  logic [4:0]  en_w;
  logic [11:0] cx;
  assign r_prio = op_a < 22'h400;
  assign r_pend = (op_a >= 22'h400) && (op_a < 22'h800);
  assign r_en   = (op_a >= 22'h800) && (op_a < 22'h80000);
  assign lo_idx = op_a[9:0];
  assign eo     = op_a - 22'h800;
  assign en_c   = eo[21:5];
  assign en_w   = eo[4:0];
  assign cx     = op_a[21:10] - 12'h200;

  function automatic logic [31:0] word_of(input vec_t v, input int w);
    logic [NWORDS*32-1:0] p;
    p = '0;
    p[NSRC-1:0] = v;
    return p[w*32 +: 32];
  endfunction

  for (genvar c = 0; c < NCTX; c++) begin : arb
    logic [IDW-1:0]    id;
    logic [PRIO_W-1:0] bp;
    always_comb begin
      id = '0;
      bp = '0;
      for (int s = 1; s < NSRC; s++)
        if (pend_q[c][s] && !clm_q[c][s] && lp_q[c][s] > bp) begin
          bp = lp_q[c][s];
          id = IDW'(s);
        end
      if (bp <= thr_q[c]) id = '0;
    end
    assign best[c] = id;
    assign irq[c]  = |id;

    assert_pend_enabled_R5: assert property (@(posedge clk) disable iff (rst)
      (pend_q[c] & ~en_q[c]) == '0);
    assert_claim_pending_R8: assert property (@(posedge clk) disable iff (rst)
      (clm_q[c] & ~pend_q[c]) == '0);
    assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (rst)
      irq[c] |-> |(pend_q[c] & ~clm_q[c]));
  end

  logic [31:0] rd;
  logic werr, hit, found, nb;
  vec_t pend_or;

  always_comb begin
    en_d = en_q; pend_d = pend_q; clm_d = clm_q; lp_d = lp_q;
    prio_d = prio_q; thr_d = thr_q;
    rd = '0; werr = 1'b0; hit = 1'b0; found = 1'b0; nb = 1'b0;
    pend_or = '0;
    for (int c = 0; c < NCTX; c++) pend_or = pend_or | pend_q[c];
    if (op_v) begin
      if (r_prio) begin
        if (!op_w) begin
          for (int s = 1; s < NSRC; s++)
            if (int'(lo_idx) == s) rd = 32'(prio_q[s]);
        end else if (int'(lo_idx) >= NSRC) begin
          werr = 1'b1;
        end else begin
          for (int s = 1; s < NSRC; s++)
            if (int'(lo_idx) == s) prio_d[s] = op_d[PRIO_W-1:0];
        end
      end else if (r_pend) begin
        if (op_w) werr = 1'b1;
        else
          for (int w = 0; w < NWORDS; w++)
            if (int'(lo_idx) == w) rd = word_of(pend_or, w);
      end else if (r_en) begin
        for (int c = 0; c < NCTX; c++)
          for (int w = 0; w < NWORDS; w++)
            if (int'(en_c) == c && int'(en_w) == w) begin
              hit = 1'b1;
              if (!op_w) rd = word_of(en_q[c], w);
              else
                for (int s = 1; s < NSRC; s++)
                  if (s / 32 == w) begin
                    nb = op_d[s % 32];
                    en_d[c][s] = nb;
                    if (nb && !en_q[c][s] && lvl_q[s]) begin
                      pend_d[c][s] = 1'b1;
                      lp_d[c][s]   = prio_q[s];
                    end else if (!nb && en_q[c][s]) begin
                      pend_d[c][s] = 1'b0;
                      clm_d[c][s]  = 1'b0;
                      lp_d[c][s]   = '0;
                    end
                  end
            end
        werr = op_w & ~hit;
      end else begin
        for (int c = 0; c < NCTX; c++)
          if (int'(cx) == c) begin
            if (lo_idx == 10'd0) begin
              hit = 1'b1;
              if (op_w) thr_d[c] = op_d[PRIO_W-1:0];
              else rd = 32'(thr_q[c]);
            end else if (lo_idx == 10'd1) begin
              hit = 1'b1;
              if (!op_w) begin
                rd = 32'(best[c]);
                for (int s = 1; s < NSRC; s++)
                  if (best[c] == IDW'(s)) clm_d[c][s] = 1'b1;
              end else begin
                for (int s = 1; s < NSRC; s++)
                  if (op_d == 32'(s) && en_q[c][s]) clm_d[c][s] = 1'b0;
              end
            end
          end
        werr = op_w & ~hit;
      end
    end
    for (int s = 1; s < NSRC; s++) begin
      found = 1'b0;
      if (src_irq[s] != lvl_q[s])
        for (int c = 0; c < NCTX; c++)
          if (!found && en_d[c][s]) begin
            found = 1'b1;
            if (src_irq[s]) begin
              pend_d[c][s] = 1'b1;
              lp_d[c][s]   = prio_d[s];
            end else begin
              pend_d[c][s] = 1'b0;
              clm_d[c][s]  = 1'b0;
              lp_d[c][s]   = '0;
            end
          end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '{default: '0}; pend_q <= '{default: '0};
      clm_q <= '{default: '0}; lp_q <= '{default: '0};
      thr_q <= '{default: '0}; prio_q <= '0; lvl_q <= '0;
    end else begin
      en_q <= en_d; pend_q <= pend_d; clm_q <= clm_d; lp_q <= lp_d;
      thr_q <= thr_d; prio_q <= prio_d;
      lvl_q <= src_irq & ~vec_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; hi_w_q <= 1'b0; hi_wa_q <= '0; hi_d_q <= '0; lo_q <= '0;
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
      if (busy_q) begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_err   <= werr;
        rsp_rdata <= {rd, lo_q};
      end else if (acc) begin
        if (bad_req) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
        end else if (req_size[0] && !werr) begin
          busy_q  <= 1'b1;
          lo_q    <= rd;
          hi_wa_q <= req_addr[23:2] + 22'd1;
          hi_w_q  <= req_write;
          hi_d_q  <= req_wdata[63:32];
        end else begin
          rsp_valid <= 1'b1;
          rsp_err   <= werr;
          rsp_rdata <= {32'b0, rd};
        end
      end
    end
  end

  assert_word_latency_R12: assert property (@(posedge clk) disable iff (rst)
    (acc && (bad_req || !req_size[0])) |=> rsp_valid);
  assert_bad_request_R10: assert property (@(posedge clk) disable iff (rst)
    (acc && bad_req) |=> (rsp_valid && rsp_err && rsp_rdata == '0));
  assert_dword_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (acc && !bad_req && req_size == 2'b11 && !req_write) |=> (!req_ready && !rsp_valid));
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int NS = 32, NC = 2, PW = 3, NW = (NS + 31) / 32;

  logic clk = 0, rst = 1;
  logic [NS-1:0] src_irq = '0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 2;
  logic [23:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [NC-1:0] irq;

  irq_router #(.NSRC(NS), .NCTX(NC), .PRIO_W(PW)) uut (
    .clk(clk), .rst(rst), .src_irq(src_irq), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq));

  always #10 clk = ~clk;

  int vectors = 0, miss = 0;
  string phase = "R7";

  int m_prio [NS];
  int m_thr [NC];
  bit m_en [NC][NS];
  bit m_pend [NC][NS];
  bit m_clm [NC][NS];
  int m_lp [NC][NS];
  bit m_lvl [NS];
  bit m_busy, m_hi_w;
  int unsigned m_hi_a;
  bit [31:0] m_hi_d, m_lo;
  bit e_rv, e_err;
  bit [63:0] e_rd;

  function automatic int m_best(int c);
    int bid = 0, bp = 0;
    for (int s = 1; s < NS; s++)
      if (m_pend[c][s] && !m_clm[c][s])
        if (bid == 0 || m_lp[c][s] > bp) begin bid = s; bp = m_lp[c][s]; end
    if (bp <= m_thr[c]) return 0;
    return bid;
  endfunction

  task automatic m_op(input bit w, input int unsigned a, input bit [31:0] d,
                      output bit [31:0] rd, output bit err);
    rd = '0; err = 0;
    if (a < 'h1000) begin
      int id = int'(a / 4);
      if (!w) begin if (id > 0 && id < NS) rd = 32'(m_prio[id]); end
      else if (id >= NS) err = 1;
      else if (id > 0) m_prio[id] = int'(d[PW-1:0]);
    end else if (a < 'h2000) begin
      int wd = int'((a - 'h1000) / 4);
      if (w) err = 1;
      else if (wd < NW)
        for (int b = 0; b < 32; b++)
          for (int c = 0; c < NC; c++)
            if (wd * 32 + b < NS && m_pend[c][wd * 32 + b]) rd[b] = 1;
    end else if (a < 'h200000) begin
      int c = int'((a - 'h2000) / 'h80);
      int wd = int'(((a - 'h2000) % 'h80) / 4);
      if (c < NC && wd < NW) begin
        for (int b = 0; b < 32; b++) begin
          int id = wd * 32 + b;
          if (id < NS && id != 0) begin
            if (!w) rd[b] = m_en[c][id];
            else begin
              if (d[b] && !m_en[c][id] && m_lvl[id]) begin
                m_pend[c][id] = 1; m_lp[c][id] = m_prio[id];
              end else if (!d[b] && m_en[c][id]) begin
                m_pend[c][id] = 0; m_clm[c][id] = 0; m_lp[c][id] = 0;
              end
              m_en[c][id] = d[b];
            end
          end
        end
      end else err = w;
    end else begin
      int c = int'((a - 'h200000) / 'h1000);
      int unsigned r = a % 'h1000;
      if (c < NC && r == 0) begin
        if (w) m_thr[c] = int'(d[PW-1:0]); else rd = 32'(m_thr[c]);
      end else if (c < NC && r == 4) begin
        if (!w) begin
          int id = m_best(c);
          rd = 32'(id);
          if (id != 0) m_clm[c][id] = 1;
        end else if (d < 32'(NS) && d != 0 && m_en[c][int'(d)]) m_clm[c][int'(d)] = 0;
      end else err = w;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin
        m_prio[s] = 0; m_lvl[s] = 0;
        for (int c = 0; c < NC; c++) begin
          m_en[c][s] = 0; m_pend[c][s] = 0; m_clm[c][s] = 0; m_lp[c][s] = 0;
        end
      end
      for (int c = 0; c < NC; c++) m_thr[c] = 0;
      m_busy = 0; e_rv = 0; e_err = 0; e_rd = '0;
    end else begin
      bit [31:0] rd;
      bit er, nv, ne;
      bit [63:0] nd;
      nv = 0; ne = 0; nd = '0;
      if (m_busy) begin
        m_op(m_hi_w, m_hi_a, m_hi_d, rd, er);
        m_busy = 0; nv = 1; ne = er; nd = {rd, m_lo};
      end else if (req_valid) begin
        if (req_size < 2 || req_addr[1:0] != 0) begin nv = 1; ne = 1; end
        else begin
          m_op(req_write, int'(req_addr), req_wdata[31:0], rd, er);
          if (req_size == 3 && !er) begin
            m_busy = 1; m_lo = rd; m_hi_w = req_write; m_hi_d = req_wdata[63:32];
            m_hi_a = (int'(req_addr) + 4) & 'hFFFFFF;
          end else begin nv = 1; ne = er; nd = {32'b0, rd}; end
        end
      end
      for (int s = 1; s < NS; s++)
        if (src_irq[s] != m_lvl[s]) begin
          for (int c = 0; c < NC; c++)
            if (m_en[c][s]) begin
              if (src_irq[s]) begin m_pend[c][s] = 1; m_lp[c][s] = m_prio[s]; end
              else begin m_pend[c][s] = 0; m_clm[c][s] = 0; m_lp[c][s] = 0; end
              break;
            end
          m_lvl[s] = src_irq[s];
        end
      e_rv = nv; e_err = ne; e_rd = nd;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [NC-1:0] ei;
      for (int c = 0; c < NC; c++) ei[c] = (m_best(c) != 0);
      vectors++;
      if (irq !== ei || rsp_valid !== e_rv ||
          (e_rv && (rsp_err !== e_err || rsp_rdata !== e_rd))) begin
        miss++;
        $display("FAIL %s: irq=%b rv=%b err=%b rd=%h expected irq=%b rv=%b err=%b rd=%h",
                 phase, irq, rsp_valid, rsp_err, rsp_rdata, ei, e_rv, e_err, e_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus(input bit w, input bit [1:0] sz, input bit [23:0] a, input bit [63:0] d,
                     input bit sc, input bit [NS-1:0] sv,
                     output bit [63:0] rd, output bit er, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    if (sc) src_irq = sv;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    rd = rsp_rdata; er = rsp_err;
  endtask

  bit [63:0] g_rd;
  bit g_er;
  int g_lat;

  task automatic wr(input bit [23:0] a, input bit [31:0] d);
    bus(1, 2, a, {32'b0, d}, 0, '0, g_rd, g_er, g_lat);
  endtask
  task automatic rd32(input bit [23:0] a);
    bus(0, 2, a, '0, 0, '0, g_rd, g_er, g_lat);
  endtask
  task automatic set_src(input bit [NS-1:0] v);
    @(negedge clk); src_irq = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R7 reset irq", 64'(irq), 0);
    phase = "R1";
    wr(24'h4, 5); wr(24'h8, 3); wr(24'hC, 'hF); wr(24'h10, 6); wr(24'h0, 7);
    rd32(24'h0); chk("R1 source0", g_rd, 0);
    rd32(24'hC); chk("R1 truncate", g_rd, 7);
    phase = "R2";
    wr(24'h200000, 9); rd32(24'h200000); chk("R2 threshold", g_rd, 1);
    wr(24'h201000, 2);
    phase = "R4";
    wr(24'h2000, 32'hFFFFFFFF); rd32(24'h2000); chk("R4 bit0", g_rd, 64'hFFFFFFFE);
    wr(24'h2080, 32'h1C);
    phase = "R6";
    set_src(32'h0E);
    rd32(24'h1000); chk("R3 pending", g_rd, 64'h0E);
    rd32(24'h201004); chk("R6 lowest context only", g_rd, 0);
    phase = "R8";
    rd32(24'h200004); chk("R8 claim first", g_rd, 3);
    rd32(24'h200004); chk("R8 claim second", g_rd, 1);
    rd32(24'h200004); chk("R8 claim third", g_rd, 2);
    rd32(24'h200004); chk("R8 claim none", g_rd, 0);
    phase = "R9";
    wr(24'h200004, 2); rd32(24'h200004); chk("R9 complete", g_rd, 2);
    wr(24'h200004, 40); wr(24'h200004, 0);
    rd32(24'h200004); chk("R9 ignored", g_rd, 0);
    phase = "R5";
    wr(24'h2000, 0); wr(24'h2080, 0); wr(24'h2080, 32'h0C);
    rd32(24'h1000); chk("R3 pending moved", g_rd, 64'h0C);
    rd32(24'h201004); chk("R5 enable rise", g_rd, 3);
    rd32(24'h201004); chk("R5 latched", g_rd, 2);
    wr(24'h201004, 3); wr(24'h201004, 2);
    phase = "R13";
    bus(0, 2, 24'h201004, '0, 1, 32'h06, g_rd, g_er, g_lat);
    chk("R13 claim with fall", g_rd, 3);
    rd32(24'h201004); chk("R13 after fall", g_rd, 2);
    wr(24'h201004, 2);
    phase = "R10";
    bus(0, 3, 24'h201000, '0, 0, '0, g_rd, g_er, g_lat);
    chk("R10 dword read", g_rd, 64'h0000000200000002);
    chk("R12 dword latency", 64'(g_lat), 2);
    phase = "R13";
    wr(24'h14, 4);
    bus(1, 2, 24'h2000, 64'h20, 1, 32'h26, g_rd, g_er, g_lat);
    chk("R12 word latency", 64'(g_lat), 1);
    rd32(24'h200004); chk("R13 enable with rise", g_rd, 5);
    phase = "R7";
    wr(24'h200004, 5); chk("R7 irq above", 64'(irq[0]), 1);
    wr(24'h200000, 4); chk("R7 irq equal", 64'(irq[0]), 0);
    wr(24'h200000, 3); chk("R7 irq restored", 64'(irq[0]), 1);
    phase = "R10";
    bus(1, 3, 24'h8, {32'd1, 32'd6}, 0, '0, g_rd, g_er, g_lat);
    rd32(24'h8); chk("R10 dword low", g_rd, 6);
    rd32(24'hC); chk("R10 dword high", g_rd, 1);
    bus(0, 0, 24'h4, '0, 0, '0, g_rd, g_er, g_lat); chk("R10 subword err", 64'(g_er), 1);
    bus(1, 2, 24'h6, 64'h7, 0, '0, g_rd, g_er, g_lat); chk("R10 misaligned err", 64'(g_er), 1);
    rd32(24'h4); chk("R10 no effect", g_rd, 5);
    phase = "R11";
    rd32(24'h3000); chk("R11 read zero", g_rd, 0); chk("R11 read ok", 64'(g_er), 0);
    wr(24'h3000, 1); chk("R11 write err", 64'(g_er), 1);
    wr(24'h1000, 1); chk("R11 pending write err", 64'(g_er), 1);
    wr(24'h200008, 1); chk("R11 hole err", 64'(g_er), 1);
    wr(24'hA0, 1); chk("R11 priority range err", 64'(g_er), 1);
    phase = "mixed R13";
    for (int i = 0; i < 400; i++) begin
      bit [23:0] a;
      bit [1:0] sz;
      int k = int'($urandom % 8);
      case (k)
        0: a = 24'(4 * ($urandom % 8));
        1: a = 24'h1000;
        2: a = 24'h2000;
        3: a = 24'h2080;
        4: a = 24'h200000;
        5: a = 24'h201000;
        6: a = 24'h200004;
        default: a = 24'h201004;
      endcase
      sz = ($urandom % 10 == 0) ? 2'($urandom % 4) : 2'd2;
      bus(1'($urandom % 2), sz, a, {32'($urandom % 16), 32'($urandom % 256)},
          1'($urandom % 2), src_irq ^ (32'h1 << ($urandom % 8)), g_rd, g_er, g_lat);
    end
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule